// File: doc/BRIEF.md
# Register-Bank Paged Address Translator

This block translates CPU logical addresses into physical addresses for the process that is running. The page table of that process lives entirely on chip, in a bank of page registers with one register per possible page number. Each register holds a frame number, a valid flag and three permission flags: read, write and execute. A logical address is split into a page number (the upper bits) and a displacement (the lower bits). The page number selects a register. If that register is valid and allows the requested kind of access, the frame number joined to the unchanged displacement forms the physical address.

If the page is unused, or the access kind is not allowed, the block returns a trap response instead of an address. Trap responses never carry a memory address. The operating system rewrites the bank at every context switch through a table write port, one entry per cycle. A clear input drops every entry to invalid in one cycle. A process with only a few pages therefore needs a clear and a handful of writes.

Requests enter on a valid/ready stream and responses leave on a valid/ready stream. `req_ready` is high when the response slot is empty or is being drained in that same cycle. A response stays on the port, unchanged, until `rsp_ready` takes it. A request must hold its address and access kind while `req_valid` is high and `req_ready` is low.

Top module: `page_xlate_unit`

## Requirements
- R1: A translated address equals frame number × PAGE_BYTES + (logical address mod PAGE_BYTES). The low log2(PAGE_BYTES) bits pass through unchanged, and the page number is the logical address divided by PAGE_BYTES.
- R2: An access to a page whose entry is invalid responds with cause 01 and physical address 0.
- R3: Access kind is coded 00 read, 01 write, 10 execute, and permission bit 0 allows read, bit 1 allows write, bit 2 allows execute. An access to a valid page whose matching permission bit is 0 responds with cause 10 and physical address 0. A permitted access responds with cause 00.
- R4: When a page is invalid, cause 01 is reported even if its permission bits would also forbid the access.
- R5: A table write (`tbl_we`) sets the entry at `tbl_idx` and takes effect from the next cycle. A request accepted in the same cycle as the write sees the entry's old contents.
- R6: `tbl_clear` makes every entry invalid from the next cycle on. It takes priority over a table write in the same cycle.
- R7: After reset, `rsp_valid` is 0 and every entry is invalid.
- R8: A request accepted at a clock edge shows up as a response just after that edge. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response address and cause stay the same.
- R10: Access kind 11 is reserved and always responds with cause 10 on a valid page.
- R11: Cause value 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_laddr | input | LA_W | Logical address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | FRAME_W+log2(PAGE_BYTES) | Physical address, 0 on a trap |
| rsp_cause | output | 2 | 00 no trap, 01 unmapped page, 10 permission denied |
| tbl_we | input | 1 | Write one page register |
| tbl_idx | input | LA_W-log2(PAGE_BYTES) | Page number of the register written |
| tbl_frame | input | FRAME_W | Frame number written |
| tbl_valid | input | 1 | Valid flag written |
| tbl_perm | input | 3 | Permission flags written: bit0 read, bit1 write, bit2 execute |
| tbl_clear | input | 1 | Invalidate all registers |

## Verification
The stall-stability and address-passthrough properties assume that requests obey the stream rule: the address and access kind stay steady while a request waits. The bench drives new request values only in cycles where it has computed that the request will be accepted, and otherwise holds them. Table writes and clears are issued freely, including in the same cycle as a request acceptance. This exercises the rule that the old entry contents apply to that request. Back-pressure is random, so responses wait for several cycles with rewrites of their own entry going on while they wait.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_UNMAPPED = 2'b01,
    CAUSE_PROT     = 2'b10
  } cause_e;

  localparam int PERM_W_BITS = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
endpackage

// File: rtl/pxu_entry_bank.sv
module pxu_entry_bank #(
  parameter int PN_W    = 4,
  parameter int FRAME_W = 10,
  localparam int NUM    = 1 << PN_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [PN_W-1:0]                   wr_idx,
  input  logic [FRAME_W-1:0]                wr_frame,
  input  logic                              wr_valid,
  input  logic [pxu_pkg::PERM_W_BITS-1:0]   wr_perm,
  input  logic                              clr,
  output logic [NUM-1:0][FRAME_W-1:0]       frame_o,
  output logic [NUM-1:0]                    valid_o,
  output logic [NUM-1:0][pxu_pkg::PERM_W_BITS-1:0] perm_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == PN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
      end else if (clr) begin
        valid_o[g] <= 1'b0;
      end else if (hit) begin
        valid_o[g] <= wr_valid;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_o[g] <= '0;
        perm_o[g]  <= '0;
      end else if (hit && !clr) begin
        frame_o[g] <= wr_frame;
        perm_o[g]  <= wr_perm;
      end
    end
  end

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (valid_o == '0));

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !clr) |->
      (frame_o[$past(wr_idx)] == $past(wr_frame)) &&
      (valid_o[$past(wr_idx)] == $past(wr_valid)) &&
      (perm_o[$past(wr_idx)] == $past(wr_perm)));
endmodule

// File: rtl/pxu_lookup.sv
module pxu_lookup #(
  parameter int PN_W    = 4,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 10,
  localparam int NUM    = 1 << PN_W,
  localparam int LA_W   = PN_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic [LA_W-1:0]                         laddr,
  input  logic [1:0]                              acc,
  input  logic [NUM-1:0][FRAME_W-1:0]             frames,
  input  logic [NUM-1:0]                          valids,
  input  logic [NUM-1:0][pxu_pkg::PERM_W_BITS-1:0] perms,
  output logic [PA_W-1:0]                         paddr,
  output logic [1:0]                              cause
);
  import pxu_pkg::*;

  logic [PN_W-1:0]        page;
  logic [OFF_W-1:0]       disp;
  logic [FRAME_W-1:0]     sel_frame;
  logic                   sel_valid;
  logic [PERM_W_BITS-1:0] sel_perm;
  logic                   allowed;
  cause_e                 cause_c;

  assign page = laddr[LA_W-1:OFF_W];
  assign disp = laddr[OFF_W-1:0];

  always_comb begin
    sel_frame = frames[page];
    sel_valid = valids[page];
    sel_perm  = perms[page];
  end

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  allowed = sel_perm[PERM_RD];
      ACC_WRITE: allowed = sel_perm[PERM_WR];
      ACC_EXEC:  allowed = sel_perm[PERM_EX];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!sel_valid)    cause_c = CAUSE_UNMAPPED;
    else if (!allowed) cause_c = CAUSE_PROT;
    else               cause_c = CAUSE_NONE;
  end

  assign cause = cause_c;
  assign paddr = (cause_c == CAUSE_NONE) ? {sel_frame, disp} : '0;
endmodule

// File: rtl/pxu_resp_stage.sv
module pxu_resp_stage #(
  parameter int PA_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PA_W-1:0] in_paddr,
  input  logic [1:0]      in_cause,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output logic [1:0]      out_cause
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_paddr <= '0;
      out_cause <= '0;
    end else if (take) begin
      out_paddr <= in_paddr;
      out_cause <= in_cause;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_paddr) && $stable(out_cause)));

  // R8
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) |-> out_valid);
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int LA_W       = 12,
  parameter int PAGE_BYTES = 256,
  parameter int FRAME_W    = 10,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PN_W      = LA_W - OFF_W,
  localparam int PA_W      = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_laddr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_cause,
  input  logic               tbl_we,
  input  logic [PN_W-1:0]    tbl_idx,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic               tbl_valid,
  input  logic [2:0]         tbl_perm,
  input  logic               tbl_clear
);
  localparam int NUM = 1 << PN_W;

  logic [NUM-1:0][FRAME_W-1:0] bank_frame;
  logic [NUM-1:0]              bank_valid;
  logic [NUM-1:0][2:0]         bank_perm;
  logic [PA_W-1:0]             lk_paddr;
  logic [1:0]                  lk_cause;

  pxu_entry_bank #(.PN_W(PN_W), .FRAME_W(FRAME_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_frame(tbl_frame),
    .wr_valid(tbl_valid), .wr_perm(tbl_perm), .clr(tbl_clear),
    .frame_o(bank_frame), .valid_o(bank_valid), .perm_o(bank_perm)
  );

  pxu_lookup #(.PN_W(PN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) lookup_i (
    .laddr(req_laddr), .acc(req_acc),
    .frames(bank_frame), .valids(bank_valid), .perms(bank_perm),
    .paddr(lk_paddr), .cause(lk_cause)
  );

  pxu_resp_stage #(.PA_W(PA_W)) resp_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_paddr(lk_paddr), .in_cause(lk_cause),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_paddr(rsp_paddr), .out_cause(rsp_cause)
  );

  // R11
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause != 2'b11));

  // R2
  trap_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 2'b00) |-> (rsp_paddr == '0));

  // R1
  disp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) && rsp_cause == 2'b00) |->
      (rsp_paddr[OFF_W-1:0] == $past(req_laddr[OFF_W-1:0])));

  // R2
  unmapped_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) &&
     !$past(bank_valid[req_laddr[LA_W-1:OFF_W]])) |->
      (rsp_cause == 2'b01));
endmodule

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;
  localparam int LA_W = 12, PAGE_BYTES = 256, FRAME_W = 10;
  localparam int OFF_W = 8, PN_W = 4, PA_W = 18, NUM = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 0;
  logic [LA_W-1:0] req_laddr = '0;
  logic [1:0] req_acc = '0, rsp_cause;
  logic [PA_W-1:0] rsp_paddr;
  logic tbl_we = 0, tbl_valid = 0, tbl_clear = 0;
  logic [PN_W-1:0] tbl_idx = '0;
  logic [FRAME_W-1:0] tbl_frame = '0;
  logic [2:0] tbl_perm = '0;

  always #5 clk = ~clk;

  page_xlate_unit dut_i (.*);

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  int  m_frame [NUM];
  bit  m_valid [NUM];
  int  m_perm  [NUM];
  bit  e_valid = 0;
  longint e_paddr = 0;
  int  e_cause = 0;
  bit  pend = 0;

  function automatic void predict(input int la, input int acc,
                                  output longint pa, output int cs);
    int pg = la / PAGE_BYTES;
    pa = 0;
    if (!m_valid[pg]) cs = 1;
    else if (acc == 3 || ((m_perm[pg] >> acc) & 1) == 0) cs = 2;
    else begin cs = 0; pa = longint'(m_frame[pg]) * PAGE_BYTES + (la % PAGE_BYTES); end
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: check outputs at negedge, drive new inputs, update model.
  task automatic step(input bit v, input int la, input int acc, input bit rdy,
                      input bit we, input int idx, input int fr, input bit vb,
                      input int pm, input bit clr);
    bit acc_ok;
    @(negedge clk);
    check("R8 rsp_valid", rsp_valid, e_valid);
    if (e_valid) begin
      check(e_cause == 0 ? "R1 paddr" : (pend ? "R9 held paddr" : "R2/R3 trap paddr"),
            rsp_paddr, e_paddr);
      check(e_cause == 1 ? "R2/R4 cause" : "R3/R10 cause", rsp_cause, e_cause);
    end
    req_valid = v; req_laddr = la[LA_W-1:0]; req_acc = acc[1:0]; rsp_ready = rdy;
    tbl_we = we; tbl_idx = idx[PN_W-1:0]; tbl_frame = fr[FRAME_W-1:0];
    tbl_valid = vb; tbl_perm = pm[2:0]; tbl_clear = clr;
    #1;
    check("R8 req_ready", req_ready, !e_valid || rdy);
    acc_ok = v && (!e_valid || rdy);
    pend = e_valid && !rdy;
    if (acc_ok) begin
      predict(la, acc, e_paddr, e_cause);   // R5: old table contents
      e_valid = 1;
    end else if (rdy) e_valid = 0;
    if (clr) foreach (m_valid[i]) m_valid[i] = 0;   // R6: clear wins
    else if (we) begin m_frame[idx] = fr; m_valid[idx] = vb; m_perm[idx] = pm; end
  endtask

  task automatic idle(); step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #1ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int la, acc;
    bit v;
    foreach (m_valid[i]) begin m_valid[i] = 0; m_frame[i] = 0; m_perm[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R7: reset state
    @(negedge clk);
    check("R7 rsp_valid after reset", rsp_valid, 0);
    check("R7 req_ready after reset", req_ready, 1);
    // R7/R2: empty table traps every page
    for (int p = 0; p < NUM; p++) step(1, p * PAGE_BYTES + p, 0, 1, 0, 0, 0, 0, 0, 0);
    idle();
    // small process: only pages 0..4 valid, mixed permissions
    for (int p = 0; p < 5; p++) step(0, 0, 0, 1, 1, p, 100 + 37 * p, 1, (p == 2) ? 3'b100 : 3'b011 + (p & 1) * 4, 0);
    for (int p = 0; p < NUM; p++)
      for (int a = 0; a < 4; a++) step(1, p * PAGE_BYTES + 8'hA5, a, 1, 0, 0, 0, 0, 0, 0);
    // R4: invalid entry with no permissions and with all permissions
    step(0, 0, 0, 1, 1, 9, 7, 0, 0, 0);
    step(1, 9 * PAGE_BYTES, 1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 10, 7, 0, 7, 0);
    step(1, 10 * PAGE_BYTES + 3, 0, 1, 0, 0, 0, 0, 0, 0);
    // R5: same-cycle write and request sees old contents, next sees new
    step(1, 3 * PAGE_BYTES + 1, 0, 1, 1, 3, 1023, 1, 7, 0);
    step(1, 3 * PAGE_BYTES + 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // R6: clear beats a write in the same cycle
    step(0, 0, 0, 1, 1, 1, 55, 1, 7, 1);
    step(1, 1 * PAGE_BYTES, 0, 1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle();
    // R9: stall with a held response while its page is rewritten
    step(0, 0, 0, 1, 1, 6, 321, 1, 7, 0);
    step(1, 6 * PAGE_BYTES + 9, 2, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6 * PAGE_BYTES + 9, 2, 0, 1, 6, 5, 1, 0, 0);
    step(1, 6 * PAGE_BYTES + 9, 2, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6 * PAGE_BYTES + 9, 2, 1, 0, 0, 0, 0, 0, 0);
    idle(); idle();
    // random traffic, holding requests while not accepted
    v = 0; la = 0; acc = 0;
    for (int c = 0; c < 4000; c++) begin
      bit rdy = ($urandom % 4) != 0;
      bit stuck = v && e_valid && !(pend ? 1'b0 : 1'b0) && e_valid;
      if (!(v && e_valid && !rdy)) begin
        v = ($urandom % 3) != 0; la = $urandom % (1 << LA_W); acc = $urandom % 4;
      end
      if (stuck && !rdy) begin end
      step(v, la, acc, rdy,
           ($urandom % 4) == 0, $urandom % NUM, $urandom % (1 << FRAME_W),
           ($urandom % 5) != 0, $urandom % 8, ($urandom % 200) == 0);
    end
    idle(); idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule